// File: doc/BRIEF.md
# Serial EEPROM Slave Emulator

This block acts as a small serial EEPROM on an SPI bus. A fast system clock oversamples the select, serial clock, data-in and pause pins. The block shifts in a one-byte command code, most significant bit first. For memory commands it then takes a 24-bit address and streams data. Read data comes back on a serial output, with an enable that marks when the pin is driven.

Writes are collected in a page buffer. The buffer is copied into the internal byte array during a self-timed busy period, and only if the transfer ends on a byte boundary. A status byte reports busy, the write-enable latch and a protection level that blocks writes to part of the array. A pause input freezes a transfer mid-byte. An unknown command makes the block disregard everything until the next deselect.

Top module: `spi_ee_slave`

## Requirements
- R1: Input bits are captured on the rising serial-clock edge and output bits change on the falling edge; transfers work with the clock idling low (mode 0) or high (mode 3).
- R2: Code 0x06 sets the write-enable latch and code 0x04 clears it; code 0x05 returns the status byte {bit7 spare, 3'b000, bits3:2 protection level, bit1 write-enable latch, bit0 busy}, refreshed for every further byte in the same select.
- R3: Code 0x03 followed by a 24-bit address streams bytes from consecutive addresses while clocks continue, wrapping from the top of the array to 0; address bits above the array size are ignored.
- R4: Code 0x02 followed by a 24-bit address loads data bytes into a page buffer; the low address byte wraps inside the 256-byte page, bytes past 256 overwrite earlier ones, and the command is ignored when the write-enable latch is clear.
- R5: A write or status write is committed only when select rises right after a complete data byte; otherwise the array is unchanged; a commit clears the write-enable latch.
- R6: A commit makes the block busy for WR_CYCLES clocks (status bit0 = 1); while busy only code 0x05 is accepted and any other code is ignored.
- R7: An unknown code makes the block ignore the rest of the transfer until select goes high.
- R8: While the pause input is low with the block selected, the output enable is low and clock and data edges are ignored; shifting resumes where it stopped.
- R9: The output enable is low whenever the block is deselected or not shifting out status or read data.
- R10: Code 0x01 (needs the write-enable latch) writes status bits 7 and 3:2; protection level 01 blocks writes to the top quarter of the array, 10 to the top half, 11 to all of it.
- R11: After reset the status byte is 0x00 and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock |
| csn | input | 1 | Select, active low |
| mosi | input | 1 | Serial data in |
| holdn | input | 1 | Pause input, active low |
| miso | output | 1 | Serial data out |
| miso_en | output | 1 | High when miso is driven, low means high impedance |

## Verification
The hardest conditions to reach from the ports are commands that arrive while an internal write cycle is running, and a pause in the middle of a byte. The bench uses a long write time. It issues a status read with two status bytes, a read command and a write-enable code right after a commit, and checks that only the status read answers. For the pause, the bench lowers the pause input between edges of a read data byte. It toggles the clock and data while paused, then confirms that the byte still arrives intact.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

    localparam logic [7:0] OP_WEN   = 8'h06;
    localparam logic [7:0] OP_WDIS  = 8'h04;
    localparam logic [7:0] OP_RSTAT = 8'h05;
    localparam logic [7:0] OP_WSTAT = 8'h01;
    localparam logic [7:0] OP_RD    = 8'h03;
    localparam logic [7:0] OP_WR    = 8'h02;

    typedef enum logic [2:0] {
        PH_OP, PH_ADDR, PH_RDATA, PH_WDATA, PH_STAT, PH_SRIN, PH_SRDONE, PH_SKIP
    } phase_e;

    typedef struct packed {
        logic       spare;
        logic [1:0] lvl;
        logic       wel;
    } sreg_t;

    typedef struct packed {
        logic       spare;
        logic [1:0] lvl;
    } snew_t;

    function automatic logic lvl_blocks(input logic [1:0] lvl, input logic [1:0] top2);
        case (lvl)
            2'b01:   return top2 == 2'b11;
            2'b10:   return top2[1];
            2'b11:   return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [7:0] stat_byte(input sreg_t s, input logic busy);
        return {s.spare, 3'b000, s.lvl, s.wel, busy};
    endfunction

endpackage

// File: rtl/spi_ee_pins.sv
module spi_ee_pins (
    input  logic clk,
    input  logic rst,
    input  logic sck,
    input  logic csn,
    input  logic mosi,
    input  logic holdn,
    output logic sel,
    output logic hold_ok,
    output logic mosi_s,
    output logic rise,
    output logic fall,
    output logic desel
);
    logic [1:0] sck_p, cs_p, mo_p, hd_p;
    logic       sck_d, cs_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_p <= '0;
            cs_p  <= 2'b11;
            mo_p  <= '0;
            hd_p  <= 2'b11;
            sck_d <= 1'b0;
            cs_d  <= 1'b1;
        end else begin
            sck_p <= {sck_p[0], sck};
            cs_p  <= {cs_p[0], csn};
            mo_p  <= {mo_p[0], mosi};
            hd_p  <= {hd_p[0], holdn};
            sck_d <= sck_p[1];
            cs_d  <= cs_p[1];
        end
    end

    assign sel     = !cs_p[1];
    assign hold_ok = hd_p[1];
    assign mosi_s  = mo_p[1];
    assign rise    = sel && hold_ok && sck_p[1] && !sck_d;
    assign fall    = sel && hold_ok && !sck_p[1] && sck_d;
    assign desel   = cs_p[1] && !cs_d;

endmodule

// File: rtl/spi_ee_store.sv
module spi_ee_store #(
    parameter int DEPTH     = 1024,
    parameter int PAGE      = 256,
    parameter int WR_CYCLES = 1000,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = $clog2(PAGE),
    localparam int GW = AW - PW,
    localparam int CW = $clog2(WR_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr_i,
    input  logic          ld_i,
    input  logic [PW-1:0] ld_idx_i,
    input  logic [7:0]    ld_data_i,
    input  logic          start_i,
    input  logic          copy_i,
    input  logic [GW-1:0] page_i,
    input  logic [1:0]    lvl_i,
    input  logic [AW-1:0] raddr_i,
    output logic [7:0]    rdata_o,
    output logic          busy_o
);
    import spi_ee_pkg::*;

    logic [7:0]      mem [DEPTH];
    logic [7:0]      pbuf [PAGE];
    logic [PAGE-1:0] pval_q;
    logic            busy_q, copy_q;
    logic [CW-1:0]   cyc_q;
    logic [GW-1:0]   page_q;
    logic [PW-1:0]   cyc_idx;
    logic [AW-1:0]   wr_addr;
    logic            wr_en;

    assign cyc_idx = cyc_q[PW-1:0];
    assign wr_addr = {page_q, cyc_idx};
    assign wr_en   = busy_q && copy_q && (32'(cyc_q) < PAGE) && pval_q[cyc_idx]
                     && !lvl_blocks(lvl_i, wr_addr[AW-1 -: 2]);

    always_ff @(posedge clk) begin
        if (ld_i) pbuf[ld_idx_i] <= ld_data_i;
        if (wr_en) mem[wr_addr] <= pbuf[cyc_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pval_q <= '0;
            busy_q <= 1'b0;
            copy_q <= 1'b0;
            cyc_q  <= '0;
            page_q <= '0;
        end else begin
            if (clr_i) pval_q <= '0;
            else if (ld_i) pval_q[ld_idx_i] <= 1'b1;
            if (start_i) begin
                busy_q <= 1'b1;
                copy_q <= copy_i;
                cyc_q  <= '0;
                page_q <= page_i;
            end else if (busy_q) begin
                if (cyc_q == CW'(WR_CYCLES - 1)) busy_q <= 1'b0;
                else cyc_q <= cyc_q + 1'b1;
            end
        end
    end

    assign rdata_o = mem[raddr_i];
    assign busy_o  = busy_q;

    // R6
    busy_start_chk: assert property (@(posedge clk) disable iff (rst) start_i |=> busy_q);
    // R6
    busy_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> $past(cyc_q) == CW'(WR_CYCLES - 1));
    // R4
    load_idle_chk: assert property (@(posedge clk) disable iff (rst) ld_i |-> !busy_q);

endmodule

// File: rtl/spi_ee_slave.sv
module spi_ee_slave #(
    parameter int MEM_BYTES  = 1024,
    parameter int PAGE_BYTES = 256,
    parameter int WR_CYCLES  = 1000,
    localparam int AW = $clog2(MEM_BYTES),
    localparam int PW = $clog2(PAGE_BYTES)
) (
    input  logic clk,
    input  logic rst,
    input  logic sck,
    input  logic csn,
    input  logic mosi,
    input  logic holdn,
    output logic miso,
    output logic miso_en
);
    import spi_ee_pkg::*;

    logic sel, hold_ok, mosi_s, rise, fall, desel;

    spi_ee_pins u_pins (
        .clk(clk), .rst(rst), .sck(sck), .csn(csn), .mosi(mosi), .holdn(holdn),
        .sel(sel), .hold_ok(hold_ok), .mosi_s(mosi_s), .rise(rise), .fall(fall),
        .desel(desel)
    );

    phase_e        phase_q;
    logic [2:0]    bit_q;
    logic [6:0]    sh_q;
    logic [1:0]    abyte_q;
    logic [AW-1:0] a_q, ptr_q, raddr, addr_now;
    logic [7:0]    tx_q, rx_byte, rdata, stat_now;
    logic          miso_q, got_q, wr_cmd_q, busy;
    sreg_t         sr_q;
    snew_t         sr_new_q;
    logic          byte_end, out_phase, wr_go, sr_go, ld, clr;

    assign rx_byte   = {sh_q, mosi_s};
    assign byte_end  = rise && (bit_q == 3'd7);
    assign addr_now  = AW'({a_q, rx_byte});
    assign raddr     = (phase_q == PH_ADDR) ? addr_now : ptr_q;
    assign stat_now  = stat_byte(sr_q, busy);
    assign out_phase = (phase_q == PH_RDATA) || (phase_q == PH_STAT);
    assign wr_go     = desel && (phase_q == PH_WDATA) && (bit_q == 3'd0) && got_q;
    assign sr_go     = desel && (phase_q == PH_SRDONE) && (bit_q == 3'd0);
    assign ld        = byte_end && (phase_q == PH_WDATA);
    assign clr       = byte_end && (phase_q == PH_OP) && (rx_byte == OP_WR) && !busy && sr_q.wel;

    spi_ee_store #(.DEPTH(MEM_BYTES), .PAGE(PAGE_BYTES), .WR_CYCLES(WR_CYCLES)) u_store (
        .clk(clk), .rst(rst), .clr_i(clr), .ld_i(ld), .ld_idx_i(ptr_q[PW-1:0]),
        .ld_data_i(rx_byte), .start_i(wr_go || sr_go), .copy_i(wr_go),
        .page_i(ptr_q[AW-1:PW]), .lvl_i(sr_q.lvl), .raddr_i(raddr),
        .rdata_o(rdata), .busy_o(busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_OP;
            bit_q    <= '0;
            sh_q     <= '0;
            abyte_q  <= '0;
            a_q      <= '0;
            ptr_q    <= '0;
            tx_q     <= '0;
            miso_q   <= 1'b0;
            got_q    <= 1'b0;
            wr_cmd_q <= 1'b0;
            sr_q     <= '0;
            sr_new_q <= '0;
        end else begin
            if (wr_go) sr_q.wel <= 1'b0;
            if (sr_go) begin
                sr_q.spare <= sr_new_q.spare;
                sr_q.lvl   <= sr_new_q.lvl;
                sr_q.wel   <= 1'b0;
            end
            if (!sel) begin
                phase_q <= PH_OP;
                bit_q   <= '0;
                got_q   <= 1'b0;
                abyte_q <= '0;
            end else begin
                if (fall && out_phase) miso_q <= tx_q[3'd7 - bit_q];
                if (rise) begin
                    bit_q <= bit_q + 3'd1;
                    sh_q  <= rx_byte[6:0];
                end
                if (byte_end) begin
                    case (phase_q)
                        PH_OP: begin
                            if (busy && rx_byte != OP_RSTAT) phase_q <= PH_SKIP;
                            else begin
                                case (rx_byte)
                                    OP_WEN:   begin sr_q.wel <= 1'b1; phase_q <= PH_SKIP; end
                                    OP_WDIS:  begin sr_q.wel <= 1'b0; phase_q <= PH_SKIP; end
                                    OP_RSTAT: begin tx_q <= stat_now; phase_q <= PH_STAT; end
                                    OP_WSTAT: phase_q <= sr_q.wel ? PH_SRIN : PH_SKIP;
                                    OP_RD:    begin wr_cmd_q <= 1'b0; phase_q <= PH_ADDR; end
                                    OP_WR:    begin
                                        wr_cmd_q <= 1'b1;
                                        phase_q  <= sr_q.wel ? PH_ADDR : PH_SKIP;
                                    end
                                    default:  phase_q <= PH_SKIP;
                                endcase
                            end
                        end
                        PH_ADDR: begin
                            a_q     <= addr_now;
                            abyte_q <= abyte_q + 2'd1;
                            if (abyte_q == 2'd2) begin
                                if (wr_cmd_q) begin
                                    ptr_q   <= addr_now;
                                    phase_q <= PH_WDATA;
                                end else begin
                                    ptr_q   <= addr_now + 1'b1;
                                    tx_q    <= rdata;
                                    phase_q <= PH_RDATA;
                                end
                            end
                        end
                        PH_RDATA: begin
                            tx_q  <= rdata;
                            ptr_q <= ptr_q + 1'b1;
                        end
                        PH_WDATA: begin
                            got_q           <= 1'b1;
                            ptr_q[PW-1:0]   <= ptr_q[PW-1:0] + 1'b1;
                        end
                        PH_STAT:  tx_q <= stat_now;
                        PH_SRIN: begin
                            sr_new_q <= '{spare: rx_byte[7], lvl: rx_byte[3:2]};
                            phase_q  <= PH_SRDONE;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    assign miso    = miso_q;
    assign miso_en = sel && hold_ok && out_phase;

    // R7
    skip_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (sel && phase_q == PH_SKIP) |=> phase_q == PH_SKIP);
    // R8
    hold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (sel && !hold_ok) |=> $stable(bit_q) && $stable(sh_q));
    // R2
    wel_set_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sr_q.wel) |-> !$past(busy));

endmodule

// File: tb/spi_ee_slave_test.sv
`timescale 1ns/1ps
module spi_ee_slave_test;
    localparam int DEPTH = 1024;
    localparam int PAGE  = 256;
    localparam int WRC   = 2000;
    localparam int HP    = 6;

    // {write address, read-back address, data}
    localparam logic [55:0] VEC [6] = '{
        {24'h000010, 24'h000010, 8'h5A},
        {24'h0003FF, 24'h0003FF, 8'hC3},
        {24'h7F0012, 24'h000012, 8'h81},
        {24'h000100, 24'h000100, 8'h3C},
        {24'h000200, 24'h000200, 8'h96},
        {24'h0002FF, 24'h0002FF, 8'hFF}
    };

    logic clk = 1'b0, rst = 1'b1, sck = 1'b0, csn = 1'b1, mosi = 1'b0, holdn = 1'b1;
    logic miso, miso_en;
    logic mode3 = 1'b0;
    logic done = 1'b0;
    int   checks = 0, errors = 0;
    logic [7:0] wbuf [0:299];
    logic [7:0] rbuf [0:7];
    logic [7:0] s, s1, s2, d;

    always #2.5 clk = ~clk;

    spi_ee_slave #(.MEM_BYTES(DEPTH), .PAGE_BYTES(PAGE), .WR_CYCLES(WRC)) uut (
        .clk(clk), .rst(rst), .sck(sck), .csn(csn), .mosi(mosi), .holdn(holdn),
        .miso(miso), .miso_en(miso_en)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic xfer_n(input logic [7:0] tx, input int nb, input int hold_at, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - nb; i--) begin
            sck = 1'b0; mosi = tx[i]; tick(HP);
            if (i == hold_at) begin
                holdn = 1'b0; tick(HP);
                chk(miso_en === 1'b0, "R8 enable during pause", 32'(miso_en), 0);
                for (int k = 0; k < 2; k++) begin
                    sck = 1'b1; mosi = ~mosi; tick(HP);
                    sck = 1'b0; tick(HP);
                end
                mosi = tx[i]; holdn = 1'b1; tick(HP);
            end
            rx[i] = miso;
            sck = 1'b1; tick(HP);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        xfer_n(tx, 8, -1, rx);
    endtask

    task automatic sel_on();
        sck = mode3; tick(HP); csn = 1'b0; tick(HP);
    endtask

    task automatic sel_off();
        sck = mode3; tick(HP); csn = 1'b1; tick(3 * HP);
    endtask

    task automatic send1(input logic [7:0] op);
        logic [7:0] r;
        sel_on(); xfer(op, r); sel_off();
    endtask

    task automatic rdsr(output logic [7:0] st);
        logic [7:0] r;
        sel_on(); xfer(8'h05, r); xfer(8'h00, st); sel_off();
    endtask

    task automatic send_addr(input logic [23:0] a);
        logic [7:0] r;
        xfer(a[23:16], r); xfer(a[15:8], r); xfer(a[7:0], r);
    endtask

    task automatic write_bytes(input logic [23:0] a, input int n);
        logic [7:0] r;
        sel_on(); xfer(8'h02, r); send_addr(a);
        for (int i = 0; i < n; i++) xfer(wbuf[i], r);
        sel_off();
    endtask

    task automatic read_bytes(input logic [23:0] a, input int n);
        logic [7:0] r;
        sel_on(); xfer(8'h03, r); send_addr(a);
        for (int i = 0; i < n; i++) xfer(8'h00, rbuf[i]);
        sel_off();
    endtask

    task automatic wait_idle();
        logic [7:0] st;
        for (int g = 0; g < 200; g++) begin
            rdsr(st);
            if (!st[0]) break;
        end
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'(i) + 8'(i >> 8) * 8'h40;
    endfunction

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        tick(5); rst = 1'b0; tick(5);
        // R11, R9 reset state
        chk(miso_en === 1'b0, "R11 enable after reset", 32'(miso_en), 0);
        rdsr(s);
        chk(s === 8'h00, "R11 status after reset", 32'(s), 0);

        // R2 latch set and clear
        send1(8'h06); rdsr(s);
        chk(s === 8'h02, "R2 latch set", 32'(s), 32'h02);
        send1(8'h04); rdsr(s);
        chk(s === 8'h00, "R2 latch cleared", 32'(s), 0);

        // R3 R4 R5 single-byte writes and read-backs from the table
        for (int k = 0; k < 6; k++) begin
            send1(8'h06);
            wbuf[0] = VEC[k][7:0];
            write_bytes(VEC[k][55:32], 1);
            wait_idle();
            read_bytes(VEC[k][31:8], 1);
            chk(rbuf[0] === VEC[k][7:0], "R4 table write/read", 32'(rbuf[0]), 32'(VEC[k][7:0]));
        end

        // R4 write ignored without latch
        wbuf[0] = 8'h99; write_bytes(24'h000010, 1); wait_idle();
        read_bytes(24'h000010, 1);
        chk(rbuf[0] === 8'h5A, "R4 write without latch", 32'(rbuf[0]), 32'h5A);

        // R4 page wrap, R3 read across page boundary
        for (int i = 0; i < 4; i++) wbuf[i] = 8'hA0 + 8'(i);
        send1(8'h06); write_bytes(24'h0000FE, 4); wait_idle();
        read_bytes(24'h0000FE, 3);
        chk(rbuf[0] === 8'hA0 && rbuf[1] === 8'hA1, "R4 page tail", {16'h0, rbuf[0], rbuf[1]}, 32'hA0A1);
        chk(rbuf[2] === 8'h3C, "R3 read crosses page", 32'(rbuf[2]), 32'h3C);
        read_bytes(24'h000000, 2);
        chk(rbuf[0] === 8'hA2 && rbuf[1] === 8'hA3, "R4 wrapped in page", {16'h0, rbuf[0], rbuf[1]}, 32'hA2A3);

        // R3 read wraps from the top of the array
        read_bytes(24'h0003FF, 2);
        chk(rbuf[0] === 8'hC3 && rbuf[1] === 8'hA2, "R3 top wrap", {16'h0, rbuf[0], rbuf[1]}, 32'hC3A2);

        // R5 select raised mid-byte discards the write
        send1(8'h06);
        sel_on(); xfer(8'h02, d); send_addr(24'h000010); xfer(8'h11, d); xfer_n(8'hFF, 3, -1, d); sel_off();
        rdsr(s);
        chk(s === 8'h02, "R5 discarded write keeps latch", 32'(s), 32'h02);
        read_bytes(24'h000010, 1);
        chk(rbuf[0] === 8'h5A, "R5 array unchanged", 32'(rbuf[0]), 32'h5A);
        send1(8'h04);

        // R6 busy behaviour
        send1(8'h06); wbuf[0] = 8'h77; write_bytes(24'h000020, 1);
        sel_on(); xfer(8'h05, d); xfer(8'h00, s1); xfer(8'h00, s2); sel_off();
        chk(s1 === 8'h01, "R6 busy status first", 32'(s1), 32'h01);
        chk(s2 === 8'h01, "R6 busy status repeated", 32'(s2), 32'h01);
        sel_on(); xfer(8'h03, d); send_addr(24'h000010); xfer(8'h00, d);
        chk(miso_en === 1'b0, "R6 read ignored while busy", 32'(miso_en), 0);
        sel_off();
        send1(8'h06); rdsr(s);
        chk(s[1] === 1'b0, "R6 latch code ignored while busy", 32'(s), 32'h01);
        wait_idle();
        read_bytes(24'h000020, 1);
        chk(rbuf[0] === 8'h77, "R6 data after busy", 32'(rbuf[0]), 32'h77);

        // R7 unknown code ignores the rest of the transfer
        sel_on(); xfer(8'hA5, d); xfer(8'h06, d); sel_off();
        rdsr(s);
        chk(s === 8'h00, "R7 unknown code", 32'(s), 0);

        // R8 pause mid-byte, R9 enable low in command phase
        sel_on();
        chk(miso_en === 1'b0, "R9 enable in command phase", 32'(miso_en), 0);
        xfer(8'h03, d); send_addr(24'h0000FE);
        xfer_n(8'h00, 8, 3, s1); xfer(8'h00, s2); sel_off();
        chk(s1 === 8'hA0 && s2 === 8'hA1, "R8 data across pause", {16'h0, s1, s2}, 32'hA0A1);
        chk(miso_en === 1'b0, "R9 enable when deselected", 32'(miso_en), 0);

        // R1 clock idling high
        mode3 = 1'b1;
        send1(8'h06); wbuf[0] = 8'h6B; write_bytes(24'h000030, 1); wait_idle();
        read_bytes(24'h000030, 1);
        chk(rbuf[0] === 8'h6B, "R1 mode 3 write/read", 32'(rbuf[0]), 32'h6B);
        mode3 = 1'b0;

        // R4 more than a page of data overwrites the buffer start
        for (int i = 0; i < 258; i++) wbuf[i] = pat(i);
        send1(8'h06); write_bytes(24'h000100, 258); wait_idle();
        read_bytes(24'h000100, 3);
        chk(rbuf[0] === pat(256) && rbuf[1] === pat(257), "R4 overflow overwrite",
            {16'h0, rbuf[0], rbuf[1]}, {16'h0, pat(256), pat(257)});
        chk(rbuf[2] === pat(2), "R4 overflow keeps rest", 32'(rbuf[2]), 32'(pat(2)));

        // R10 status write and protection
        send1(8'h06);
        sel_on(); xfer(8'h01, d); xfer(8'h84, d); sel_off();
        wait_idle(); rdsr(s);
        chk(s === 8'h84, "R10 status written", 32'(s), 32'h84);
        send1(8'h06); wbuf[0] = 8'hEE; write_bytes(24'h0003FF, 1); wait_idle();
        read_bytes(24'h0003FF, 1);
        chk(rbuf[0] === 8'hC3, "R10 top quarter blocked", 32'(rbuf[0]), 32'hC3);
        send1(8'h06); wbuf[0] = 8'hD4; write_bytes(24'h000200, 1); wait_idle();
        read_bytes(24'h000200, 1);
        chk(rbuf[0] === 8'hD4, "R10 lower area writable", 32'(rbuf[0]), 32'hD4);
        send1(8'h06);
        sel_on(); xfer(8'h01, d); xfer(8'h00, d); sel_off();
        wait_idle(); rdsr(s);
        chk(s === 8'h00, "R10 status restored", 32'(s), 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule